// File: doc/BRIEF.md
# Bit-Serial CRC Encoder and Checker

This block computes a cyclic redundancy check one bit per clock. While the `absorb` control is high, each bit on `din` is folded into a remainder register. The register divides the incoming stream, taken as a polynomial, by a generator polynomial of degree `DEG`. The leading coefficient of the generator (x^DEG) is implied and never supplied.

Once the block has absorbed a data word, the controller drops `absorb` for exactly `DEG` cycles. During those cycles the remainder leaves on `dout`, most significant bit first, and can be appended to the transmitted word as parity. To check a received word, its data and appended parity are absorbed together. An `err` flag then shows whether the remainder is nonzero.

The generator is chosen in one of two ways. A nonzero `POLY` parameter fixes it at build time. A `POLY` of zero makes the block read it from the `gen` bus at run time. The `err` flag is present only when `HAS_FLAG` is set. `DEG` may range from 2 to 32.

Top module: `serial_crc`

## Requirements
- R1: A high `rst` at a clock edge clears the remainder to zero, and it takes priority over `absorb`. After reset, `err` is low and every parity bit shifted out is 0.
- R2: Bits absorbed while `absorb` is high leave in the register the remainder of M(x)·x^DEG divided by G(x). Here M(x) is the absorbed stream with the first bit at the highest power.
- R3: While `absorb` is low, `dout` presents the top remainder bit, so the `DEG` output cycles give the parity with the highest power first. While `absorb` is high, `dout` is 0.
- R4: Zeros shift in while parity is shifted out. After `DEG` output cycles the remainder is zero and `err` is low.
- R5: With `POLY` = 0, bit i of `gen` is the coefficient of x^i for i in 0..DEG-1. A `gen` of all zeros therefore gives the generator x^DEG.
- R6: With `POLY` nonzero, bit i of `POLY` is the coefficient of x^i, and the `gen` input has no effect on the parity.
- R7: With `HAS_FLAG` = 1, `err` is high exactly when the current remainder is nonzero. It follows the register in the same cycle, with no added clock delay.
- R8: With `HAS_FLAG` = 0, `err` is held at 0.
- R9: When a data word is absorbed followed by its own parity, the remainder ends at zero and `err` is low. A word with one bit flipped leaves `err` high whenever G(x) has a nonzero x^0 term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the remainder, active high |
| din | input | 1 | Serial data bit |
| absorb | input | 1 | High: absorb `din`; low: shift parity out |
| gen | input | DEG | Run-time generator coefficients x^0..x^(DEG-1); used only when `POLY` = 0 |
| dout | output | 1 | Serial parity bit, highest power first |
| err | output | 1 | High when the remainder is nonzero (0 when `HAS_FLAG` = 0) |

## Verification
The bench builds two copies of the block. The first has `DEG` = 8, `POLY` = 0 and the flag enabled. It is driven with random generators, and with the all-zero and all-one generators as directed cases. This reaches the run-time coefficient path and the error flag, including decode with appended parity and with single-bit corruption. The second copy has `DEG` = 5, `POLY` = x^5+x^2+1 and the flag disabled. Its `gen` bus carries random values, so it reaches the fixed-generator selection, the proof that `gen` is ignored, and the constant-zero flag.

// File: rtl/serial_crc.sv
module serial_crc #(
  parameter int DEG      = 8,
  parameter int POLY     = 0,
  parameter bit HAS_FLAG = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           din,
  input  logic           absorb,
  input  logic [DEG-1:0] gen,
  output logic           dout,
  output logic           err
);

  localparam logic [DEG-1:0] FIXED_TAPS = DEG'(POLY);

  logic [DEG-1:0] rem;
  logic [DEG-1:0] taps;
  logic           fb;

  assign taps = (POLY == 0) ? gen : FIXED_TAPS;
  assign fb   = din ^ rem[DEG-1];

  always_ff @(posedge clk) begin
    if (rst)
      rem <= '0;
    else if (absorb)
      rem <= {rem[DEG-2:0], 1'b0} ^ (fb ? taps : '0);
    else
      rem <= {rem[DEG-2:0], 1'b0};
  end

  assign dout = ~absorb & rem[DEG-1];

  generate
    if (HAS_FLAG) begin : g_flag
      assign err = |rem;
    end else begin : g_noflag
      assign err = 1'b0;
    end
  endgenerate

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rem == '0));

  // R3
  quiet_absorb_chk: assert property (@(posedge clk) disable iff (rst)
    absorb |-> !dout);

  // R4
  shift_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!absorb && !$past(absorb) && !$past(rst)) |-> (dout == $past(rem[DEG-2])));

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(absorb));

endmodule

// File: tb/test_serial_crc.sv
module test_serial_crc;
  localparam int DV = 8;
  localparam int DF = 5;
  localparam int PF = 5'h05;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, din = 1'b0, absorb = 1'b1;
  logic [DV-1:0] gen_v = '0;
  logic [DF-1:0] gen_f = '0;
  logic dout_v, err_v, dout_f, err_f;

  serial_crc #(.DEG(DV), .POLY(0), .HAS_FLAG(1)) i_serial_crc (
    .clk(clk), .rst(rst), .din(din), .absorb(absorb), .gen(gen_v),
    .dout(dout_v), .err(err_v));

  serial_crc #(.DEG(DF), .POLY(PF), .HAS_FLAG(0)) i_serial_crc_fix (
    .clk(clk), .rst(rst), .din(din), .absorb(absorb), .gen(gen_f),
    .dout(dout_f), .err(err_f));

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic msg [0:79];
  int mlen;

  function automatic logic [31:0] model_rem(int deg, logic [31:0] g, int n);
    logic [32:0] r = '0;
    logic [32:0] divisor = (33'd1 << deg) | 33'(g);
    for (int i = 0; i < n + deg; i++) begin
      r = (r << 1) | 33'((i < n) ? msg[i] : 1'b0);
      if (r[deg]) r = r ^ divisor;
    end
    return r[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic r, logic a, logic b);
    @(negedge clk);
    rst = r; absorb = a; din = b;
    #1;
  endtask

  task automatic absorb_word(int n);
    drive(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 1'b1, msg[i]);
      chk("R3 quiet while absorbing", 32'(dout_v), 32'd0);
    end
  endtask

  task automatic run_trial(logic [DV-1:0] g);
    logic [31:0] ev, ef;
    logic [DV-1:0] par;
    int pos;
    gen_v = g;
    gen_f = DF'($urandom);
    ev = model_rem(DV, 32'(g), mlen);
    ef = model_rem(DF, 32'(PF), mlen);
    absorb_word(mlen);
    for (int k = 0; k < DV; k++) begin
      drive(1'b0, 1'b0, 1'b0);
      if (k == 0) begin
        chk("R7 err after absorb", 32'(err_v), 32'(ev != 0));
        chk("R8 flag disabled", 32'(err_f), 32'd0);
      end
      if (k % 3 == 1) gen_f = DF'($urandom);
      #1;
      par[DV-1-k] = dout_v;
      chk("R2/R5 parity bit", 32'(dout_v), 32'(ev[DV-1-k]));
      if (k < DF) chk("R6 fixed parity bit", 32'(dout_f), 32'(ef[DF-1-k]));
    end
    drive(1'b0, 1'b0, 1'b0);
    chk("R4 empty after output", 32'(err_v), 32'd0);
    // R9 decode with parity appended
    for (int k = 0; k < DV; k++) msg[mlen+k] = par[DV-1-k];
    absorb_word(mlen + DV);
    drive(1'b0, 1'b0, 1'b0);
    chk("R9 clean word", 32'(err_v), 32'd0);
    pos = int'($urandom_range(mlen + DV - 1, 0));
    msg[pos] = ~msg[pos];
    absorb_word(mlen + DV);
    drive(1'b0, 1'b0, 1'b0);
    chk("R9 corrupted word", 32'(err_v), 32'(model_rem(DV, 32'(g), mlen + DV) != 0));
    if (g[0]) chk("R9 single flip caught", 32'(err_v), 32'd1);
  endtask

  task automatic fill_random(int n);
    mlen = n;
    for (int i = 0; i < n; i++) msg[i] = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: absorb junk, then reset with absorb still high
    gen_v = 8'h07;
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R1 err after reset", 32'(err_v), 32'd0);
    for (int k = 0; k < DV; k++) begin
      if (k > 0) drive(1'b0, 1'b0, 1'b0);
      chk("R1 zero parity after reset", 32'(dout_v), 32'd0);
    end
    // R5 directed: all-zero generator, then all-ones
    fill_random(12);
    run_trial(8'h00);
    fill_random(1);
    msg[0] = 1'b1;
    run_trial(8'hFF);
    fill_random(20);
    run_trial(8'h07);
    for (int t = 0; t < 30; t++) begin
      fill_random(int'($urandom_range(40, 1)));
      run_trial(DV'($urandom) | 8'h01);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule